// File: doc/BRIEF.md
# Two-Port Word Memory with Collision Arbitration

The block is a 4096-word by 16-bit storage array with two independent access ports, called left and right, both clocked by one clock. Each port has its own select, read-output enable, write strobe, a 12-bit address, write data and two byte-lane enables. A write changes only the lanes that are enabled. A read returns the addressed word one clock later, with disabled lanes forced to zero.

When both selected ports point at the same word, an arbiter chooses an owner. A port that was already sitting on that address in the previous cycle keeps it against a newcomer. When both arrive in the same cycle, the left port wins. The arbiter then reports a collision flag toward the losing port. A mode input sets the role of the flag pins. In master role the block drives the flags from its arbiter, and it drops any write from the losing port. In slave role it drives the flags low and treats its per-port busy inputs as write blocks, so that an arbiter elsewhere can decide for a set of cascaded blocks.

Top module: `dpm_dualport`

## Requirements
- R1: A write on either port stores the word at its 12-bit address. A read (select high, output enable high, write strobe low) presents that word on the port's read bus in the cycle after the read.
- R2: Write lanes are masked. The upper enable (`*_hi`) guards bits 15:8 and the lower enable (`*_lo`) guards bits 7:0, and lanes not enabled keep their stored value.
- R3: Read lanes are masked in the same way, with disabled lanes returned as zero. Any cycle that is not a read returns a read bus of all zeros one cycle later.
- R4: Both ports may read the same word in one cycle. Both receive the stored word and nothing is written.
- R5: A collision exists only when both ports are selected with equal addresses. The loser's flag rises in the cycle after the collision cycle and falls in the cycle after the collision ends.
- R6: In a collision, a port that was selected on the same address in the previous cycle wins against a port that was not. An owner that holds its address keeps the win for as long as the collision lasts.
- R7: When both ports reach the shared address in the same cycle, the left port wins.
- R8: In master role (`master_mode`=1), a write by the losing port in a collision cycle is discarded, and the busy inputs have no effect.
- R9: In slave role (`master_mode`=0), both busy outputs stay low. A high busy input discards that port's write in the same cycle, and internal arbitration discards nothing.
- R10: In slave role, if both ports write the same word in one cycle without a block, the left port's enabled lanes take the left data and the right port's remaining enabled lanes take the right data.
- R11: Synchronous active-high reset clears both read buses, both busy outputs and the arbitration history. The array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1: drive busy flags and arbitrate writes; 0: obey busy inputs |
| l_sel | input | 1 | Left port select |
| l_oe | input | 1 | Left read-output enable |
| l_wr | input | 1 | Left write strobe |
| l_hi | input | 1 | Left upper-lane enable |
| l_lo | input | 1 | Left lower-lane enable |
| l_addr | input | 12 | Left word address |
| l_wdata | input | 16 | Left write data |
| l_busy_in | input | 1 | Left write block (slave role) |
| l_rdata | output | 16 | Left read data, one cycle after the read |
| l_busy | output | 1 | Left collision flag (master role) |
| r_sel | input | 1 | Right port select |
| r_oe | input | 1 | Right read-output enable |
| r_wr | input | 1 | Right write strobe |
| r_hi | input | 1 | Right upper-lane enable |
| r_lo | input | 1 | Right lower-lane enable |
| r_addr | input | 12 | Right word address |
| r_wdata | input | 16 | Right write data |
| r_busy_in | input | 1 | Right write block (slave role) |
| r_rdata | output | 16 | Right read data, one cycle after the read |
| r_busy | output | 1 | Right collision flag (master role) |

## Verification
An error in the arbitration history shows up as a flag on the wrong port or at the wrong time, one cycle after the collision cycle. It also shows up later as a wrong word on a read of the contested address, because the winner's data was overwritten or lost. A lane-mask or write-gating error leaves a corrupt word in the array, and it becomes visible on the next read of that word, possibly many cycles later. The bench therefore keeps a full reference image. It reads addresses continuously from a small, heavily contested window so that such corruption surfaces within a few cycles.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
    parameter int ADDR_W = 12;
    parameter int DATA_W = 16;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int HALF_W = DATA_W / 2;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        logic              sel;
        logic              oe;
        logic              wr;
        logic              hi;
        logic              lo;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } port_req_t;

    function automatic logic [DATA_W-1:0] lane_mask(input logic hi, input logic lo);
        return {{HALF_W{hi}}, {HALF_W{lo}}};
    endfunction
endpackage

// File: rtl/dpm_arbiter.sv
module dpm_arbiter
    import dpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sel,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_sel,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_lose,
    output logic              r_lose,
    output logic              l_flag,
    output logic              r_flag
);
    logic              l_sel_q, r_sel_q;
    logic [ADDR_W-1:0] l_addr_q, r_addr_q;
    owner_e            owner_q, owner_d;
    logic              clash, l_stay, r_stay;

    assign clash  = l_sel && r_sel && (l_addr == r_addr);
    assign l_stay = l_sel_q && (l_addr_q == l_addr);
    assign r_stay = r_sel_q && (r_addr_q == r_addr);

    always_comb begin
        owner_d = OWN_NONE;
        if (clash) begin
            if (l_stay && r_stay)
                owner_d = owner_q;
            else if (r_stay)
                owner_d = OWN_RIGHT;
            else
                owner_d = OWN_LEFT;
        end
    end

    assign l_lose = (owner_d == OWN_RIGHT);
    assign r_lose = (owner_d == OWN_LEFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            l_sel_q  <= 1'b0;
            r_sel_q  <= 1'b0;
            l_addr_q <= '0;
            r_addr_q <= '0;
            owner_q  <= OWN_NONE;
            l_flag   <= 1'b0;
            r_flag   <= 1'b0;
        end else begin
            l_sel_q  <= l_sel;
            r_sel_q  <= r_sel;
            l_addr_q <= l_addr;
            r_addr_q <= r_addr;
            owner_q  <= owner_d;
            l_flag   <= l_lose;
            r_flag   <= r_lose;
        end
    end
endmodule

// File: rtl/dpm_port_gate.sv
module dpm_port_gate
    import dpm_pkg::*;
(
    input  port_req_t         req,
    input  logic              master_mode,
    input  logic              lose,
    input  logic              busy_in,
    output logic              wr_go,
    output logic              rd_go,
    output logic [DATA_W-1:0] lanes
);
    logic blocked;

    assign blocked = master_mode ? lose : busy_in;
    assign lanes   = lane_mask(req.hi, req.lo);
    assign wr_go   = req.sel && req.wr && !blocked && (req.hi || req.lo);
    assign rd_go   = req.sel && req.oe && !req.wr;
endmodule

// File: rtl/dpm_array.sv
module dpm_array
    import dpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              l_wr_go,
    input  logic              l_rd_go,
    input  logic [DATA_W-1:0] l_lanes,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              r_wr_go,
    input  logic              r_rd_go,
    input  logic [DATA_W-1:0] r_lanes,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic [DATA_W-1:0] r_rdata
);
    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] l_old, r_old, l_new, r_new, both_new;
    logic              same_word;

    assign l_old     = store[l_addr];
    assign r_old     = store[r_addr];
    assign r_new     = (r_old & ~r_lanes) | (r_wdata & r_lanes);
    assign l_new     = (l_old & ~l_lanes) | (l_wdata & l_lanes);
    assign both_new  = (r_new & ~l_lanes) | (l_wdata & l_lanes);
    assign same_word = l_wr_go && r_wr_go && (l_addr == r_addr);

    always_ff @(posedge clk) begin
        if (r_wr_go && !same_word)
            store[r_addr] <= r_new;
        if (l_wr_go)
            store[l_addr] <= same_word ? both_new : l_new;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            l_rdata <= '0;
            r_rdata <= '0;
        end else begin
            l_rdata <= l_rd_go ? (l_old & l_lanes) : '0;
            r_rdata <= r_rd_go ? (r_old & r_lanes) : '0;
        end
    end
endmodule

// File: rtl/dpm_dualport.sv
module dpm_dualport
    import dpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              master_mode,
    input  logic              l_sel,
    input  logic              l_oe,
    input  logic              l_wr,
    input  logic              l_hi,
    input  logic              l_lo,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              l_busy_in,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_busy,
    input  logic              r_sel,
    input  logic              r_oe,
    input  logic              r_wr,
    input  logic              r_hi,
    input  logic              r_lo,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic              r_busy_in,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_busy
);
    port_req_t         l_req, r_req;
    logic              l_lose, r_lose, l_flag, r_flag;
    logic              l_wr_go, r_wr_go, l_rd_go, r_rd_go;
    logic [DATA_W-1:0] l_lanes, r_lanes;

    assign l_req = '{sel: l_sel, oe: l_oe, wr: l_wr, hi: l_hi, lo: l_lo,
                     addr: l_addr, wdata: l_wdata};
    assign r_req = '{sel: r_sel, oe: r_oe, wr: r_wr, hi: r_hi, lo: r_lo,
                     addr: r_addr, wdata: r_wdata};

    dpm_arbiter u_arb (
        .clk(clk), .rst(rst),
        .l_sel(l_sel), .l_addr(l_addr),
        .r_sel(r_sel), .r_addr(r_addr),
        .l_lose(l_lose), .r_lose(r_lose),
        .l_flag(l_flag), .r_flag(r_flag)
    );

    dpm_port_gate u_gate_l (
        .req(l_req), .master_mode(master_mode), .lose(l_lose),
        .busy_in(l_busy_in), .wr_go(l_wr_go), .rd_go(l_rd_go), .lanes(l_lanes)
    );

    dpm_port_gate u_gate_r (
        .req(r_req), .master_mode(master_mode), .lose(r_lose),
        .busy_in(r_busy_in), .wr_go(r_wr_go), .rd_go(r_rd_go), .lanes(r_lanes)
    );

    dpm_array u_mem (
        .clk(clk), .rst(rst),
        .l_wr_go(l_wr_go), .l_rd_go(l_rd_go), .l_lanes(l_lanes),
        .l_addr(l_req.addr), .l_wdata(l_req.wdata),
        .r_wr_go(r_wr_go), .r_rd_go(r_rd_go), .r_lanes(r_lanes),
        .r_addr(r_req.addr), .r_wdata(r_req.wdata),
        .l_rdata(l_rdata), .r_rdata(r_rdata)
    );

    assign l_busy = master_mode && l_flag;
    assign r_busy = master_mode && r_flag;
endmodule

// File: rtl/dpm_dualport_chk.sv
module dpm_dualport_chk
    import dpm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              master_mode,
    input logic              l_sel,
    input logic              l_oe,
    input logic              l_wr,
    input logic [ADDR_W-1:0] l_addr,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_busy,
    input logic              r_sel,
    input logic              r_oe,
    input logic              r_wr,
    input logic [ADDR_W-1:0] r_addr,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_busy
);
    a_r11_reset_clears: assert property (@(posedge clk)
        rst |=> (!l_busy && !r_busy && l_rdata == '0 && r_rdata == '0));

    a_r6_single_loser: assert property (@(posedge clk) disable iff (rst)
        !(l_busy && r_busy));

    a_r5_l_needs_clash: assert property (@(posedge clk) disable iff (rst)
        l_busy |-> $past(l_sel && r_sel && l_addr == r_addr));

    a_r5_r_needs_clash: assert property (@(posedge clk) disable iff (rst)
        r_busy |-> $past(l_sel && r_sel && l_addr == r_addr));

    a_r9_slave_quiet: assert property (@(posedge clk) disable iff (rst)
        !master_mode |-> (!l_busy && !r_busy));

    a_r3_l_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !(l_sel && l_oe && !l_wr) |=> (l_rdata == '0));

    a_r3_r_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !(r_sel && r_oe && !r_wr) |=> (r_rdata == '0));
endmodule

bind dpm_dualport dpm_dualport_chk u_chk (
    .clk(clk), .rst(rst), .master_mode(master_mode),
    .l_sel(l_sel), .l_oe(l_oe), .l_wr(l_wr), .l_addr(l_addr),
    .l_rdata(l_rdata), .l_busy(l_busy),
    .r_sel(r_sel), .r_oe(r_oe), .r_wr(r_wr), .r_addr(r_addr),
    .r_rdata(r_rdata), .r_busy(r_busy)
);

// File: tb/sim_dpm_dualport.sv
`timescale 1ns/1ps
module sim_dpm_dualport;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        master_mode = 1'b1;
    logic        l_sel, l_oe, l_wr, l_hi, l_lo, l_busy_in;
    logic        r_sel, r_oe, r_wr, r_hi, r_lo, r_busy_in;
    logic [11:0] l_addr, r_addr;
    logic [15:0] l_wdata, r_wdata, l_rdata, r_rdata;
    logic        l_busy, r_busy;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done  = 0;

    logic [15:0] ref_mem [4096];
    logic        pl_sel, pr_sel;
    logic [11:0] pl_addr, pr_addr;
    int          p_owner;

    always #10 clk = ~clk;

    dpm_dualport u0 (
        .clk(clk), .rst(rst), .master_mode(master_mode),
        .l_sel(l_sel), .l_oe(l_oe), .l_wr(l_wr), .l_hi(l_hi), .l_lo(l_lo),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_busy_in(l_busy_in),
        .l_rdata(l_rdata), .l_busy(l_busy),
        .r_sel(r_sel), .r_oe(r_oe), .r_wr(r_wr), .r_hi(r_hi), .r_lo(r_lo),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_busy_in(r_busy_in),
        .r_rdata(r_rdata), .r_busy(r_busy)
    );

    function automatic logic [15:0] lanes16(input logic hi, input logic lo);
        return {{8{hi}}, {8{lo}}};
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                          input logic [15:0] m);
        return (old & ~m) | (d & m);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic idle();
        l_sel = 0; l_oe = 0; l_wr = 0; l_hi = 0; l_lo = 0; l_busy_in = 0;
        r_sel = 0; r_oe = 0; r_wr = 0; r_hi = 0; r_lo = 0; r_busy_in = 0;
        l_addr = '0; r_addr = '0; l_wdata = '0; r_wdata = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        pl_sel = 0; pr_sel = 0; pl_addr = '0; pr_addr = '0; p_owner = 0;
    endtask

    // One cycle: inputs already driven after a negedge. Model, clock, compare.
    task automatic step(input string tag);
        logic        clash, ls, rs, wl, wr_;
        int          win;
        logic [15:0] el, er, rn;
        clash = l_sel && r_sel && (l_addr == r_addr);
        ls = pl_sel && (pl_addr == l_addr);
        rs = pr_sel && (pr_addr == r_addr);
        win = 0;
        if (clash) win = (ls && rs) ? p_owner : ((rs && !ls) ? 2 : 1);
        el = (l_sel && l_oe && !l_wr) ? (ref_mem[l_addr] & lanes16(l_hi, l_lo)) : 16'h0;
        er = (r_sel && r_oe && !r_wr) ? (ref_mem[r_addr] & lanes16(r_hi, r_lo)) : 16'h0;
        wl  = l_sel && l_wr && (master_mode ? (win != 2) : !l_busy_in);
        wr_ = r_sel && r_wr && (master_mode ? (win != 1) : !r_busy_in);
        if (wr_) begin
            rn = merge(ref_mem[r_addr], r_wdata, lanes16(r_hi, r_lo));
            ref_mem[r_addr] = rn;
        end
        if (wl) ref_mem[l_addr] = merge(ref_mem[l_addr], l_wdata, lanes16(l_hi, l_lo));
        @(posedge clk);
        #1;
        check(tag, "l_rdata", l_rdata, el);
        check(tag, "r_rdata", r_rdata, er);
        check(tag, "l_busy", {15'b0, l_busy}, {15'b0, master_mode && win == 2});
        check(tag, "r_busy", {15'b0, r_busy}, {15'b0, master_mode && win == 1});
        pl_sel = l_sel; pr_sel = r_sel; pl_addr = l_addr; pr_addr = r_addr; p_owner = win;
        @(negedge clk);
    endtask

    task automatic lw(input logic [11:0] a, input logic [15:0] d, input logic hi, input logic lo);
        l_sel = 1; l_oe = 0; l_wr = 1; l_hi = hi; l_lo = lo; l_addr = a; l_wdata = d;
    endtask
    task automatic rw(input logic [11:0] a, input logic [15:0] d, input logic hi, input logic lo);
        r_sel = 1; r_oe = 0; r_wr = 1; r_hi = hi; r_lo = lo; r_addr = a; r_wdata = d;
    endtask
    task automatic lr(input logic [11:0] a);
        l_sel = 1; l_oe = 1; l_wr = 0; l_hi = 1; l_lo = 1; l_addr = a;
    endtask
    task automatic rr(input logic [11:0] a);
        r_sel = 1; r_oe = 1; r_wr = 0; r_hi = 1; r_lo = 1; r_addr = a;
    endtask

    task automatic random_phase(input int cycles, input string tag);
        for (int i = 0; i < cycles; i++) begin
            logic [31:0] x;
            x = $urandom;
            l_sel = (x[3:0] != 0); l_oe = x[4]; l_wr = x[5] & x[6];
            l_hi = x[7]; l_lo = x[8]; l_busy_in = x[9] & x[10];
            l_addr = x[11] ? {9'd0, x[14:12]} : 12'($urandom);
            l_wdata = 16'($urandom);
            x = $urandom;
            r_sel = (x[3:0] != 0); r_oe = x[4]; r_wr = x[5] & x[6];
            r_hi = x[7]; r_lo = x[8]; r_busy_in = x[9] & x[10];
            r_addr = x[11] ? {9'd0, x[14:12]} : 12'($urandom);
            if (x[15]) r_addr = l_addr;
            r_wdata = 16'($urandom);
            step(tag);
        end
        idle();
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        idle();
        master_mode = 1;
        // R11: reset state at the ports
        do_reset();
        #1;
        check("R11", "l_rdata", l_rdata, 16'h0);
        check("R11", "r_rdata", r_rdata, 16'h0);
        check("R11", "busy", {14'b0, l_busy, r_busy}, 16'h0);
        // R1: fill the array, left low half, right high half
        for (int a = 0; a < 2048; a++) begin
            lw(12'(a), 16'(a * 16'h3b5 + 7), 1, 1);
            rw(12'(a + 2048), 16'(a * 16'h1c9 + 3), 1, 1);
            step("R1");
        end
        idle();
        lr(12'd5); rr(12'd4095); step("R1");
        idle(); step("R1");
        // R2: upper lane only, then R3: lower lane read
        lw(12'd9, 16'hABCD, 1, 0); step("R2");
        idle(); lr(12'd9); step("R2");
        idle(); lr(12'd9); l_hi = 0; step("R3");
        idle(); l_sel = 1; l_oe = 0; l_addr = 12'd9; step("R3");
        // R4: both read the same word
        idle(); lr(12'd20); rr(12'd20); step("R4");
        idle(); step("R4");
        // R7: simultaneous write to the same word, left wins
        lw(12'd30, 16'h1111, 1, 1); rw(12'd30, 16'h2222, 1, 1); step("R7");
        idle(); lr(12'd30); step("R7");
        check("R7", "word30", l_rdata, 16'h1111);
        idle(); step("R5");
        // R6: right arrives first, left joins and its write is dropped (R8)
        rr(12'd40); step("R6");
        rr(12'd40); lw(12'd40, 16'h5555, 1, 1); step("R6");
        rr(12'd40); lw(12'd40, 16'h6666, 1, 1); step("R8");
        check("R6", "l_busy held", {15'b0, l_busy}, 16'h1);
        idle(); rr(12'd40); step("R5");
        idle(); step("R5");
        // R8: busy inputs ignored in master role
        lw(12'd50, 16'h7777, 1, 1); l_busy_in = 1; step("R8");
        idle(); lr(12'd50); step("R8");
        check("R8", "word50", l_rdata, 16'h7777);
        idle();
        random_phase(3000, "R1/R2/R3/R5/R6/R8");
        // Slave role
        master_mode = 0;
        do_reset();
        // R9: busy input blocks; internal arbitration does not
        lw(12'd60, 16'h8888, 1, 1); l_busy_in = 1; step("R9");
        idle(); lr(12'd60); step("R9");
        check("R9", "word60 kept", l_rdata !== 16'h8888, 1'b1);
        idle(); rr(12'd61); step("R9");
        rr(12'd61); lw(12'd61, 16'h9999, 1, 1); step("R9");
        idle(); rr(12'd61); step("R9");
        check("R9", "word61", r_rdata, 16'h9999);
        // R10: both write, left lanes dominate
        idle(); lw(12'd70, 16'hAA00, 1, 0); rw(12'd70, 16'h33CC, 1, 1); step("R10");
        idle(); lr(12'd70); step("R10");
        check("R10", "word70", l_rdata, 16'hAACC);
        idle();
        random_phase(3000, "R9/R10");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule